// File: doc/BRIEF.md
# Buffered 16-bit Timer with Compare Trigger

This block is a 16-bit up-counting timer that sits on an 8-bit register bus. It runs from a single synchronous clock. A count-enable input, divided by a programmable prescaler, advances it while the timer is switched on. When the counter wraps from all ones to zero it sets a sticky overflow flag, and that flag drives an interrupt line when interrupts are enabled.

Software normally touches the wide counter through a one-byte shadow of the high half. In buffered mode, reading the low byte snapshots the live high byte into the shadow, so the following high-byte read returns a value that matches the low byte. A high-byte write only fills the shadow, and the next low-byte write loads both halves at once. With buffering off, the high-byte address reaches the live counter directly.

A 16-bit compare register can turn the timer into a periodic event source. When compare-trigger mode is on and the counter advances while equal to the compare value, the counter returns to zero instead. A one-cycle conversion-start pulse is then sent to a neighbouring converter. This reset never sets the overflow flag, and a bus write to the counter in the same cycle overrides it.

Top module: `buffered_timer16`

## Requirements
- R1: After reset the counter, control, compare and shadow registers and the overflow flag are all zero, and `irq` and `conv_start` are low.
- R2: The counter advances by one on each prescaler terminal count. The prescaler advances only in cycles where `cnt_en` is high and the run bit is set, and divides by 1, 2, 4 or 8 for a divide-select value of 0, 1, 2 or 3. Otherwise the counter holds.
- R3: An advance from 0xFFFF gives 0x0000 and sets the overflow flag, which stays set. `irq` equals the flag AND the interrupt-enable bit.
- R4: Writing the status register with bit 0 = 0 clears the flag, and writing it with bit 0 = 1 has no effect. If a wrap happens in the same cycle as a clearing write, the flag stays set.
- R5: In buffered mode, a read of address 3 returns the shadow byte. A read of address 2 returns the counter low byte and, at the same clock edge, copies the counter high byte into the shadow.
- R6: In buffered mode, a write to address 3 changes only the shadow. A write to address 2 loads the counter with {shadow, written byte} in one cycle.
- R7: With buffering off, address 3 reads and writes the counter high byte directly, and a write to address 2 changes only the low byte.
- R8: A write to address 2 clears the prescaler. A write to address 3 leaves the prescaler phase unchanged.
- R9: With trigger mode on, an advance while the counter equals the compare value loads zero instead. `conv_start` is then high for exactly the next cycle, which gives a period of compare+1 advances.
- R10: A trigger reset never sets the overflow flag, even when the compare value is 0xFFFF.
- R11: When a write that changes the counter coincides with a trigger, the written value is loaded, no reset occurs and no `conv_start` pulse follows.
- R12: The register map is as follows. Address 0 is control: bit 0 run, bits 2:1 divide select, bit 3 buffered mode, bit 4 trigger mode, bit 5 interrupt enable, and bits 7:6 read as zero. Address 1 is status, with the flag in bit 0. Address 2 is the counter low byte and address 3 the high byte or shadow. Addresses 4 and 5 are the compare low and high bytes, readable and writable. Other addresses read as zero. `bus_rdata` shows the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count enable into the prescaler |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| irq | output | 1 | Overflow interrupt request |
| conv_start | output | 1 | One-cycle conversion-start pulse on trigger |

## Verification
The assertions check on every cycle the relations between neighbouring pieces of logic:
- an overflow always leaves the flag set and the counter at zero;
- a trigger leaves the counter cleared with the pulse raised, and never raises the flag;
- a low-byte write always lands;
- a buffered low-byte read refreshes the shadow;
- the counter and prescaler hold when nothing acts on them.

Only the bench's scenarios can show the behaviours that span several accesses. These are tear-free 16-bit readback, the deferred high-byte commit, prescaler phase surviving a high-byte write, the exact pulse period, and a write overriding a same-cycle trigger.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int ADDR_W    = 3;
    localparam int DIV_SEL_W = 2;

    typedef logic [ADDR_W-1:0] addr_t;

    localparam addr_t A_CTRL   = 3'd0;
    localparam addr_t A_STAT   = 3'd1;
    localparam addr_t A_CNT_LO = 3'd2;
    localparam addr_t A_CNT_HI = 3'd3;
    localparam addr_t A_CMP_LO = 3'd4;
    localparam addr_t A_CMP_HI = 3'd5;

    typedef struct packed {
        logic                 irq_en;
        logic                 trig_en;
        logic                 buffered;
        logic [DIV_SEL_W-1:0] div_sel;
        logic                 run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tmr16_prescaler.sv
module tmr16_prescaler #(
    parameter  int SEL_W = 2,
    localparam int PRE_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_d;
    logic [PRE_W-1:0] mask;

    // Low sel bits of the phase counter must all be ones for a terminal count.
    always_comb begin
        mask = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < int'(sel)) begin
                mask[i] = 1'b1;
            end
        end
    end

    assign tick = adv && ((pre_q & mask) == mask);

    always_comb begin
        pre_d = pre_q;
        if (clr) begin
            pre_d = '0;
        end else if (adv) begin
            pre_d = pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_d;
        end
    end

    property p_clear;
        @(posedge clk) disable iff (!rst_n) clr |=> (pre_q == '0);
    endproperty
    assert_pre_clear_R8: assert property (p_clear);

    property p_hold;
        @(posedge clk) disable iff (!rst_n) (!adv && !clr) |=> $stable(pre_q);
    endproperty
    assert_pre_hold_R2: assert property (p_hold);

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              trig_en,
    input  logic              buffered,
    input  logic [CNT_W-1:0]  cmp,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] buf_hi,
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf_set,
    output logic              trig_fire,
    output logic              conv_start
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             conv_q;
    logic             cnt_wr;
    logic             at_max;

    assign cnt_wr    = wr_lo || (wr_hi && !buffered);
    assign at_max    = &cnt_q;
    assign trig_fire = trig_en && tick && (cnt_q == cmp);
    assign ovf_set   = tick && at_max && !trig_fire && !cnt_wr;

    // Next count: bus write, then trigger reset, then advance.
    always_comb begin
        cnt_d = cnt_q;
        if (wr_lo) begin
            cnt_d = buffered ? {buf_hi, wdata} : {cnt_q[CNT_W-1:DATA_W], wdata};
        end else if (wr_hi && !buffered) begin
            cnt_d = {wdata, cnt_q[DATA_W-1:0]};
        end else if (trig_fire) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            conv_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            conv_q <= trig_fire && !cnt_wr;
        end
    end

    assign cnt        = cnt_q;
    assign conv_start = conv_q;

    property p_hold;
        @(posedge clk) disable iff (!rst_n)
            (!tick && !cnt_wr) |=> $stable(cnt_q);
    endproperty
    assert_cnt_hold_R2: assert property (p_hold);

    property p_wrap;
        @(posedge clk) disable iff (!rst_n) ovf_set |=> (cnt_q == '0);
    endproperty
    assert_wrap_zero_R3: assert property (p_wrap);

    property p_lo_load;
        @(posedge clk) disable iff (!rst_n)
            wr_lo |=> (cnt_q[DATA_W-1:0] == $past(wdata));
    endproperty
    assert_lo_load_R11: assert property (p_lo_load);

    property p_trig;
        @(posedge clk) disable iff (!rst_n)
            (trig_fire && !cnt_wr) |=> ((cnt_q == '0) && conv_q);
    endproperty
    assert_trig_reset_R9: assert property (p_trig);

endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  addr_t             bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ovf_set,
    input  logic              trig_fire,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  cmp,
    output logic [DATA_W-1:0] buf_hi,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);

    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  cmp_q;
    logic [DATA_W-1:0] buf_q;
    logic              flag_q;
    logic              wr_ctrl;
    logic              wr_stat;
    logic              wr_hi;
    logic              wr_cmp_lo;
    logic              wr_cmp_hi;
    logic              rd_lo;
    logic              unused_wbits;

    assign wr_ctrl   = bus_wr && (bus_addr == A_CTRL);
    assign wr_stat   = bus_wr && (bus_addr == A_STAT);
    assign wr_hi     = bus_wr && (bus_addr == A_CNT_HI);
    assign wr_cmp_lo = bus_wr && (bus_addr == A_CMP_LO);
    assign wr_cmp_hi = bus_wr && (bus_addr == A_CMP_HI);
    assign rd_lo     = bus_rd && !bus_wr && (bus_addr == A_CNT_LO);

    assign unused_wbits = ^bus_wdata[DATA_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            cmp_q  <= '0;
            buf_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            end
            if (wr_cmp_lo) begin
                cmp_q[DATA_W-1:0] <= bus_wdata;
            end
            if (wr_cmp_hi) begin
                cmp_q[CNT_W-1:DATA_W] <= bus_wdata;
            end
            if (ovf_set) begin
                flag_q <= 1'b1;
            end else if (wr_stat && !bus_wdata[0]) begin
                flag_q <= 1'b0;
            end
            if (wr_hi && ctrl_q.buffered) begin
                buf_q <= bus_wdata;
            end else if (rd_lo && ctrl_q.buffered) begin
                buf_q <= cnt[CNT_W-1:DATA_W];
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (bus_addr)
            A_CTRL:   rdata = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
            A_STAT:   rdata = {{(DATA_W-1){1'b0}}, flag_q};
            A_CNT_LO: rdata = cnt[DATA_W-1:0];
            A_CNT_HI: rdata = ctrl_q.buffered ? buf_q : cnt[CNT_W-1:DATA_W];
            A_CMP_LO: rdata = cmp_q[DATA_W-1:0];
            A_CMP_HI: rdata = cmp_q[CNT_W-1:DATA_W];
            default:  rdata = '0;
        endcase
    end

    assign ctrl   = ctrl_q;
    assign cmp    = cmp_q;
    assign buf_hi = buf_q;
    assign irq    = flag_q && ctrl_q.irq_en;

    property p_flag_set;
        @(posedge clk) disable iff (!rst_n) ovf_set |=> flag_q;
    endproperty
    assert_flag_sticky_R3: assert property (p_flag_set);

    property p_trig_noflag;
        @(posedge clk) disable iff (!rst_n) (trig_fire && !flag_q) |=> !flag_q;
    endproperty
    assert_trig_noflag_R10: assert property (p_trig_noflag);

    property p_capture;
        @(posedge clk) disable iff (!rst_n)
            (rd_lo && ctrl_q.buffered) |=> (buf_q == $past(cnt[CNT_W-1:DATA_W]));
    endproperty
    assert_shadow_capture_R5: assert property (p_capture);

endmodule

// File: rtl/buffered_timer16.sv
module buffered_timer16
    import tmr16_pkg::*;
#(
    parameter  int DATA_W = 8,
    localparam int CNT_W  = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              conv_start
);

    ctrl_t             ctrl;
    logic [CNT_W-1:0]  cmp;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] buf_hi;
    logic              tick;
    logic              adv;
    logic              wr_lo;
    logic              wr_hi;
    logic              ovf_set;
    logic              trig_fire;

    assign adv   = ctrl.run && cnt_en;
    assign wr_lo = bus_wr && (bus_addr == A_CNT_LO);
    assign wr_hi = bus_wr && (bus_addr == A_CNT_HI);

    tmr16_prescaler #(
        .SEL_W (DIV_SEL_W)
    ) u_prescaler (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .clr   (wr_lo),
        .sel   (ctrl.div_sel),
        .tick  (tick)
    );

    tmr16_core #(
        .DATA_W (DATA_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .trig_en    (ctrl.trig_en),
        .buffered   (ctrl.buffered),
        .cmp        (cmp),
        .wr_lo      (wr_lo),
        .wr_hi      (wr_hi),
        .wdata      (bus_wdata),
        .buf_hi     (buf_hi),
        .cnt        (cnt),
        .ovf_set    (ovf_set),
        .trig_fire  (trig_fire),
        .conv_start (conv_start)
    );

    tmr16_regs #(
        .DATA_W (DATA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .cnt       (cnt),
        .ovf_set   (ovf_set),
        .trig_fire (trig_fire),
        .ctrl      (ctrl),
        .cmp       (cmp),
        .buf_hi    (buf_hi),
        .rdata     (bus_rdata),
        .irq       (irq)
    );

endmodule

// File: tb/buffered_timer16_tb.sv
module buffered_timer16_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       conv_start;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    buffered_timer16 u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_en     (cnt_en),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq),
        .conv_start (conv_start)
    );

    // Expected state, derived from the requirements.
    logic [5:0]  m_ctrl = '0;
    logic [15:0] m_cnt  = '0;
    logic [15:0] m_cmp  = '0;
    logic [7:0]  m_buf  = '0;
    logic [2:0]  m_pre  = '0;
    logic        m_flag = 1'b0;
    logic        m_conv = 1'b0;

    always @(posedge clk) begin : ref_model
        logic        adv, tk, wl, wh, cw, trg, ovs;
        logic [2:0]  msk;
        logic [15:0] n_cnt;
        logic [7:0]  n_buf;
        if (!rst_n) begin
            m_ctrl = '0; m_cnt = '0; m_cmp = '0; m_buf = '0;
            m_pre = '0; m_flag = 1'b0; m_conv = 1'b0;
        end else begin
            adv = m_ctrl[0] && cnt_en;
            msk = 3'((4'd1 << m_ctrl[2:1]) - 4'd1);
            tk  = adv && ((m_pre & msk) == msk);
            wl  = bus_wr && (bus_addr == 3'd2);
            wh  = bus_wr && (bus_addr == 3'd3);
            cw  = wl || (wh && !m_ctrl[3]);
            trg = m_ctrl[4] && tk && (m_cnt == m_cmp);
            ovs = tk && (m_cnt == 16'hFFFF) && !trg && !cw;
            n_cnt = m_cnt;
            if (wl) n_cnt = m_ctrl[3] ? {m_buf, bus_wdata} : {m_cnt[15:8], bus_wdata};
            else if (wh && !m_ctrl[3]) n_cnt = {bus_wdata, m_cnt[7:0]};
            else if (trg) n_cnt = 16'h0000;
            else if (tk) n_cnt = m_cnt + 16'd1;
            n_buf = m_buf;
            if (wh && m_ctrl[3]) n_buf = bus_wdata;
            else if (bus_rd && !bus_wr && bus_addr == 3'd2 && m_ctrl[3]) n_buf = m_cnt[15:8];
            if (wl) m_pre = 3'd0;
            else if (adv) m_pre = m_pre + 3'd1;
            if (ovs) m_flag = 1'b1;
            else if (bus_wr && bus_addr == 3'd1 && !bus_wdata[0]) m_flag = 1'b0;
            if (bus_wr && bus_addr == 3'd0) m_ctrl = bus_wdata[5:0];
            if (bus_wr && bus_addr == 3'd4) m_cmp[7:0] = bus_wdata;
            if (bus_wr && bus_addr == 3'd5) m_cmp[15:8] = bus_wdata;
            m_conv = trg && !cw;
            m_cnt = n_cnt;
            m_buf = n_buf;
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {2'b00, m_ctrl};
            3'd1: return {7'd0, m_flag};
            3'd2: return m_cnt[7:0];
            3'd3: return m_ctrl[3] ? m_buf : m_cnt[15:8];
            3'd4: return m_cmp[7:0];
            3'd5: return m_cmp[15:8];
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] a);
        case (a)
            3'd1: return "R4";
            3'd2: return "R2";
            3'd3: return "R5";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One bus cycle: drive at the falling edge, sample the cycle's results.
    task automatic step(input logic w, input logic r, input logic [2:0] a, input logic [7:0] d,
                        input logic en, output logic [7:0] rv, output logic cv);
        @(negedge clk);
        cv = conv_start;
        chk("R3", "irq vs model", {15'd0, irq}, {15'd0, m_flag && m_ctrl[5]});
        chk("R9", "conv_start vs model", {15'd0, conv_start}, {15'd0, m_conv});
        bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; cnt_en = en;
        #1;
        rv = bus_rdata;
        if (r) chk(req_of(a), "rdata vs model", {8'd0, rv}, {8'd0, exp_rd(a)});
    endtask

    logic [7:0] rv;
    logic       cv;

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(1'b1, 1'b0, a, d, 1'b0, rv, cv);
    endtask

    task automatic rd(input logic [2:0] a);
        step(1'b0, 1'b1, a, 8'h00, 1'b0, rv, cv);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, rv, cv);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a));
            chk("R1", "reset register", {8'd0, rv}, 16'h0000);
        end
        chk("R1", "reset irq", {15'd0, irq}, 16'd0);
        chk("R1", "reset conv_start", {15'd0, conv_start}, 16'd0);

        // R12 register map
        wr(3'd0, 8'hFF); rd(3'd0);
        chk("R12", "ctrl upper bits zero", {8'd0, rv}, 16'h003F);
        wr(3'd4, 8'h34); wr(3'd5, 8'h12);
        rd(3'd4); chk("R12", "cmp lo", {8'd0, rv}, 16'h0034);
        rd(3'd5); chk("R12", "cmp hi", {8'd0, rv}, 16'h0012);
        rd(3'd7); chk("R12", "unmapped", {8'd0, rv}, 16'h0000);

        // R2 counting, hold and divide
        wr(3'd0, 8'h01); wr(3'd3, 8'h00); wr(3'd2, 8'h00);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, rv, cv);
        rd(3'd2); chk("R2", "hold without cnt_en", {8'd0, rv}, 16'h0000);
        run(7); rd(3'd2); chk("R2", "divide by 1", {8'd0, rv}, 16'h0007);
        wr(3'd0, 8'h05); wr(3'd2, 8'h00);
        run(12); rd(3'd2); chk("R2", "divide by 4", {8'd0, rv}, 16'h0003);
        wr(3'd0, 8'h04); wr(3'd2, 8'h00);
        run(6); rd(3'd2); chk("R2", "hold with run clear", {8'd0, rv}, 16'h0000);

        // R8 prescaler clearing
        wr(3'd0, 8'h07); wr(3'd2, 8'h00);
        run(5); wr(3'd3, 8'h00); run(3);
        rd(3'd2); chk("R8", "hi write keeps phase", {8'd0, rv}, 16'h0001);
        wr(3'd2, 8'h10); run(5); wr(3'd2, 8'h10); run(3);
        rd(3'd2); chk("R8", "lo write clears phase", {8'd0, rv}, 16'h0010);

        // R3 and R6 wrap in buffered mode
        wr(3'd0, 8'h29); wr(3'd3, 8'hFF); wr(3'd2, 8'hFE);
        rd(3'd2); chk("R6", "buffered 16-bit load lo", {8'd0, rv}, 16'h00FE);
        rd(3'd3); chk("R6", "buffered 16-bit load hi", {8'd0, rv}, 16'h00FF);
        run(2);
        rd(3'd2); chk("R3", "wrap lo", {8'd0, rv}, 16'h0000);
        rd(3'd3); chk("R3", "wrap hi", {8'd0, rv}, 16'h0000);
        rd(3'd1); chk("R3", "flag set", {8'd0, rv}, 16'h0001);
        chk("R3", "irq high", {15'd0, irq}, 16'd1);

        // R4 flag clearing
        wr(3'd1, 8'h01); rd(3'd1); chk("R4", "write one no effect", {8'd0, rv}, 16'h0001);
        wr(3'd1, 8'h00); rd(3'd1); chk("R4", "write zero clears", {8'd0, rv}, 16'h0000);
        chk("R4", "irq low", {15'd0, irq}, 16'd0);
        wr(3'd3, 8'hFF); wr(3'd2, 8'hFF);
        step(1'b1, 1'b0, 3'd1, 8'h00, 1'b1, rv, cv);
        rd(3'd1); chk("R4", "set wins over clear", {8'd0, rv}, 16'h0001);
        wr(3'd1, 8'h00);

        // R5 and R6 shadow behaviour
        wr(3'd0, 8'h08); wr(3'd3, 8'h12); wr(3'd2, 8'hFF);
        rd(3'd2); chk("R5", "lo read", {8'd0, rv}, 16'h00FF);
        rd(3'd3); chk("R5", "captured hi", {8'd0, rv}, 16'h0012);
        wr(3'd3, 8'h55);
        rd(3'd3); chk("R6", "hi write fills shadow", {8'd0, rv}, 16'h0055);
        rd(3'd2); rd(3'd3); chk("R6", "live hi untouched", {8'd0, rv}, 16'h0012);

        // R7 direct mode
        wr(3'd0, 8'h00); wr(3'd3, 8'hAB);
        rd(3'd3); chk("R7", "direct hi", {8'd0, rv}, 16'h00AB);
        rd(3'd2); chk("R7", "lo untouched", {8'd0, rv}, 16'h00FF);
        wr(3'd2, 8'h01);
        rd(3'd3); chk("R7", "hi kept on lo write", {8'd0, rv}, 16'h00AB);

        // R9 trigger period
        wr(3'd0, 8'h11); wr(3'd4, 8'h03); wr(3'd5, 8'h00);
        wr(3'd3, 8'h00); wr(3'd2, 8'h00);
        for (int i = 1; i <= 9; i++) begin
            step(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, rv, cv);
            chk("R9", "pulse pattern", {15'd0, cv}, {15'd0, (i == 5 || i == 9)});
        end

        // R10 trigger at all ones
        wr(3'd1, 8'h00); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
        wr(3'd3, 8'hFF); wr(3'd2, 8'hFE);
        run(2);
        step(1'b0, 1'b1, 3'd2, 8'h00, 1'b0, rv, cv);
        chk("R10", "pulse at all ones", {15'd0, cv}, 16'd1);
        chk("R10", "counter cleared", {8'd0, rv}, 16'h0000);
        rd(3'd1); chk("R10", "no flag", {8'd0, rv}, 16'h0000);

        // R11 write beats trigger
        wr(3'd4, 8'h05); wr(3'd5, 8'h00); wr(3'd3, 8'h00); wr(3'd2, 8'h05);
        step(1'b1, 1'b0, 3'd2, 8'h20, 1'b1, rv, cv);
        step(1'b0, 1'b1, 3'd2, 8'h00, 1'b0, rv, cv);
        chk("R11", "no pulse", {15'd0, cv}, 16'd0);
        chk("R11", "written value", {8'd0, rv}, 16'h0020);

        // Random traffic against the expected state
        for (int i = 0; i < 4000; i++) begin
            int op;
            logic [2:0] a;
            logic [7:0] d;
            logic en;
            op = int'($urandom % 10);
            a  = 3'($urandom % 6);
            d  = 8'($urandom);
            en = ($urandom % 4) != 0;
            case (op)
                0, 1, 2, 3: step(1'b0, 1'b0, a, d, en, rv, cv);
                4:          step(1'b0, 1'b1, a, d, en, rv, cv);
                5:          step(1'b1, 1'b0, 3'd0, d | 8'h01, en, rv, cv);
                6:          step(1'b1, 1'b0, 3'd1, d, en, rv, cv);
                7:          step(1'b1, 1'b0, 3'(2 + ($urandom % 2)), d, en, rv, cv);
                8:          step(1'b1, 1'b0, 3'(4 + ($urandom % 2)), d & 8'h07, en, rv, cv);
                default: begin
                    step(1'b0, 1'b1, 3'd2, d, en, rv, cv);
                    step(1'b0, 1'b1, 3'd3, d, en, rv, cv);
                end
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule